// File: doc/BRIEF.md
# Indexed Configuration Register Window

This block gives a host indirect access to a bank of byte-wide controller configuration registers through two I/O ports. The host writes a register index into an index port and then reads or writes the selected register through a data port four addresses higher. The bank covers slots 0x50 to 0x5B. It holds a configuration byte, a control byte, per-drive timing bytes, a secondary-channel byte, a burst byte and a scratch byte. Slot 0x5A is a hole.

A strap input places the window at one of two bases. Several registers mix writable control bits with read-only status bits: the revision code, the active-base flag and the two per-channel interrupt-pending flags. Some control bits also drive the block's outputs. These are the read-ahead disables for the four drives and the secondary channel enable.

The host sees plain single-cycle read and write strobes. Read data is combinational while the read strobe is high. A hit flag shows when the window is driving the read data.

Top module: `idx_cfg_window`

## Requirements
- R1: A write at the base address loads the 8-bit index. A read at the base returns that index. A write or read at base+4 transfers the register the index selects.
- R2: With `altBase` low the base is 0x178. With `altBase` high the base is 0x78. An access at any other address does nothing: `ioRdHit` stays 0, `ioRdData` is 0x00, and neither the index nor any register changes.
- R3: Bit 5 of register 0x50 reads 1 exactly when the window sits at 0x78. Writes to that bit are ignored.
- R4: Bits 1:0 of register 0x50 always read the nonzero parameter `REV_ID` (default 2). Writes to them are ignored.
- R5: A high `priIrq` sets bit 2 of register 0x50 and a high `secIrq` sets bit 4 of register 0x57, visible from the next cycle. Each stays set until its status-read pulse (`priStatRd` or `secStatRd`). Host writes to these bits are ignored.
- R6: After reset, every writable bit is 0, except register 0x59, which reads 0x40.
- R7: Index 0x5A and any index outside 0x50..0x5B read 0xFF. A write to such an index changes nothing.
- R8: Registers 0x51 to 0x56, 0x58, 0x59 and the scratch register 0x5B read back the full byte last written. In register 0x50, bits 7, 6, 4 and 3 are writable. In register 0x57, every bit except bit 4 is writable.
- R9: `raOff[0]` and `raOff[1]` follow bits 6 and 7 of register 0x51, and `secEn` follows bit 3 of 0x51. `raOff[2]` and `raOff[3]` follow bits 2 and 3 of register 0x57. All change on the clock edge that takes the write.
- R10: When an interrupt input and its status-read pulse are high in the same cycle, the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | 16 | Host I/O address |
| ioWr | input | 1 | Host write strobe, one cycle per write |
| ioRd | input | 1 | Host read strobe |
| ioWrData | input | 8 | Host write data |
| ioRdData | output | 8 | Read data, 0x00 when the window is not addressed |
| ioRdHit | output | 1 | High while a read hits the index or data port |
| altBase | input | 1 | Base select strap: 0 selects 0x178, 1 selects 0x78 |
| priIrq | input | 1 | Primary channel drive interrupt |
| secIrq | input | 1 | Secondary channel drive interrupt |
| priStatRd | input | 1 | Pulse: primary channel status was read |
| secStatRd | input | 1 | Pulse: secondary channel status was read |
| raOff | output | 4 | Read-ahead disable, one bit per drive |
| secEn | output | 1 | Secondary channel enable |

## Verification
The bench writes a distinct byte to every index from 0x40 to 0x6F and reads each one back. A design with a wrong write mask would corrupt the revision, base-flag or pending bits. A design that decoded the hole or an out-of-range index would return stored data instead of 0xFF, or would clobber a neighbour.

Accesses at the inactive base are checked with the strap in both positions. A decoder that ignored the strap would move the index or a register.

The pending bits are checked against host writes of all ones and all zeros, against the clear pulse, and against a set and a clear in the same cycle. A wrong priority would lose an interrupt.

The read-ahead and enable outputs are compared after each control write. A swapped bit would show up on the wrong drive.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  localparam int          NUM_SLOTS  = 12;
  localparam logic [7:0]  IDX_FIRST  = 8'h50;
  localparam int          CFG_SLOT   = 0;
  localparam int          CTRL_SLOT  = 1;
  localparam int          CH2_SLOT   = 7;
  localparam int          BURST_SLOT = 9;
  localparam int          HOLE_SLOT  = 10;

  typedef struct packed {
    logic idxWr;
    logic idxRd;
    logic dataWr;
    logic dataRd;
  } winStrobe_t;

  // bits the host may change in each slot
  function automatic logic [7:0] slotWrMask(input int slot);
    case (slot)
      CFG_SLOT:  return 8'hD8;
      CH2_SLOT:  return 8'hEF;
      HOLE_SLOT: return 8'h00;
      default:   return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] slotRstVal(input int slot);
    return (slot == BURST_SLOT) ? 8'h40 : 8'h00;
  endfunction

endpackage

// File: rtl/cfgwin_ctrl.sv
module cfgwin_ctrl
  import cfgwin_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_MAIN = 16'h0178,
  parameter logic [ADDR_W-1:0] BASE_ALT  = 16'h0078,
  parameter int                DATA_OFS  = 4
) (
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic              altBase,
  output winStrobe_t        strb,
  output logic              portHit
);

  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(DATA_OFS);

  logic [ADDR_W-1:0] baseSel;
  logic              idxSel;
  logic              dataSel;

  always_comb begin
    baseSel = altBase ? BASE_ALT : BASE_MAIN;
    idxSel  = (ioAddr == baseSel);
    dataSel = (ioAddr == baseSel + OFS);
  end

  always_comb begin
    strb.idxWr  = ioWr && idxSel;
    strb.idxRd  = ioRd && idxSel;
    strb.dataWr = ioWr && dataSel;
    strb.dataRd = ioRd && dataSel;
    portHit     = strb.idxRd || strb.dataRd;
  end

endmodule

// File: rtl/cfgwin_regs.sv
module cfgwin_regs
  import cfgwin_pkg::*;
#(
  parameter logic [1:0] REV_ID = 2'd2
) (
  input  logic       clk,
  input  logic       rstN,
  input  winStrobe_t strb,
  input  logic [7:0] wrData,
  input  logic       altBase,
  input  logic       priIrq,
  input  logic       secIrq,
  input  logic       priClr,
  input  logic       secClr,
  output logic [7:0] rdData,
  output logic [3:0] raOff,
  output logic       secEn
);

  logic [7:0] idxQ;
  logic [7:0] slotQ  [NUM_SLOTS];
  logic [7:0] rdSlot [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slotWr;
  logic       priPend;
  logic       secPend;
  logic [7:0] dataQ;

  // index register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           idxQ <= 8'h00;
    else if (strb.idxWr) idxQ <= wrData;
  end

  // per-slot write decode and read composition
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    localparam logic [7:0] M = slotWrMask(g);
    assign slotWr[g] = strb.dataWr && (idxQ == IDX_FIRST + 8'(g));
    if (g == CFG_SLOT) begin : gCfg
      assign rdSlot[g] = (slotQ[g] & M) | {2'b00, altBase, 2'b00, priPend, REV_ID};
    end else if (g == CH2_SLOT) begin : gCh2
      assign rdSlot[g] = (slotQ[g] & M) | {3'b000, secPend, 4'b0000};
    end else if (g == HOLE_SLOT) begin : gHole
      assign rdSlot[g] = 8'hFF;
    end else begin : gPlain
      assign rdSlot[g] = slotQ[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SLOTS; s++) slotQ[s] <= slotRstVal(s);
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++)
        if (slotWr[s])
          slotQ[s] <= (slotQ[s] & ~slotWrMask(s)) | (wrData & slotWrMask(s));
    end
  end

  // sticky pending flags, set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      priPend <= 1'b0;
      secPend <= 1'b0;
    end else begin
      priPend <= priIrq || (priPend && !priClr);
      secPend <= secIrq || (secPend && !secClr);
    end
  end

  always_comb begin
    dataQ = 8'hFF;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (idxQ == IDX_FIRST + 8'(s)) dataQ = rdSlot[s];
  end

  always_comb begin
    if (strb.idxRd)       rdData = idxQ;
    else if (strb.dataRd) rdData = dataQ;
    else                  rdData = 8'h00;
  end

  assign raOff = {slotQ[CH2_SLOT][3], slotQ[CH2_SLOT][2],
                  slotQ[CTRL_SLOT][7], slotQ[CTRL_SLOT][6]};
  assign secEn = slotQ[CTRL_SLOT][3];

endmodule

// File: rtl/idx_cfg_window.sv
module idx_cfg_window
  import cfgwin_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_MAIN = 16'h0178,
  parameter logic [ADDR_W-1:0] BASE_ALT  = 16'h0078,
  parameter int                DATA_OFS  = 4,
  parameter logic [1:0]        REV_ID    = 2'd2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [7:0]        ioWrData,
  output logic [7:0]        ioRdData,
  output logic              ioRdHit,
  input  logic              altBase,
  input  logic              priIrq,
  input  logic              secIrq,
  input  logic              priStatRd,
  input  logic              secStatRd,
  output logic [3:0]        raOff,
  output logic              secEn
);

  winStrobe_t strb;

  cfgwin_ctrl #(
    .ADDR_W(ADDR_W), .BASE_MAIN(BASE_MAIN), .BASE_ALT(BASE_ALT), .DATA_OFS(DATA_OFS)
  ) u_ctrl (
    .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd), .altBase(altBase),
    .strb(strb), .portHit(ioRdHit)
  );

  cfgwin_regs #(.REV_ID(REV_ID)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(ioWrData), .altBase(altBase),
    .priIrq(priIrq), .secIrq(secIrq), .priClr(priStatRd), .secClr(secStatRd),
    .rdData(ioRdData), .raOff(raOff), .secEn(secEn)
  );

endmodule

// File: rtl/idx_cfg_window_chk.sv
module idx_cfg_window_chk #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_MAIN = 16'h0178,
  parameter logic [ADDR_W-1:0] BASE_ALT  = 16'h0078,
  parameter int                DATA_OFS  = 4,
  parameter logic [1:0]        REV_ID    = 2'd2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioWr,
  input logic              ioRd,
  input logic [7:0]        ioWrData,
  input logic [7:0]        ioRdData,
  input logic              ioRdHit,
  input logic              altBase,
  input logic              priIrq,
  input logic [3:0]        raOff,
  input logic              secEn
);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] dataAddr;
  logic [7:0]        shadowIdx;
  logic              armed;
  logic              dataRead;
  logic              badIdx;

  assign base     = altBase ? BASE_ALT : BASE_MAIN;
  assign dataAddr = base + ADDR_W'(DATA_OFS);
  assign dataRead = ioRd && !ioWr && (ioAddr == dataAddr);
  assign badIdx   = (shadowIdx < 8'h50) || (shadowIdx > 8'h5B) || (shadowIdx == 8'h5A);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowIdx <= 8'h00;
      armed     <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (ioWr && ioAddr == base) shadowIdx <= ioWrData;
    end
  end

  p_index_readback_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && !ioWr && ioAddr == base) |-> (ioRdHit && ioRdData == shadowIdx));

  p_foreign_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && ioAddr != base && ioAddr != dataAddr) |-> (!ioRdHit && ioRdData == 8'h00));

  p_base_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead && shadowIdx == 8'h50) |-> (ioRdData[5] == altBase));

  p_revision_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead && shadowIdx == 8'h50) |-> (ioRdData[1:0] == REV_ID));

  p_irq_seen_r5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(priIrq) && dataRead && shadowIdx == 8'h50) |-> ioRdData[2]);

  p_unimpl_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead && badIdx) |-> (ioRdData == 8'hFF));

  p_ctrl_outputs_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioAddr == dataAddr && shadowIdx == 8'h51)
      |=> (secEn == $past(ioWrData[3]) && raOff[1:0] == $past(ioWrData[7:6])));

endmodule

bind idx_cfg_window idx_cfg_window_chk #(
  .ADDR_W(ADDR_W), .BASE_MAIN(BASE_MAIN), .BASE_ALT(BASE_ALT),
  .DATA_OFS(DATA_OFS), .REV_ID(REV_ID)
) u_chk (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
  .ioWrData(ioWrData), .ioRdData(ioRdData), .ioRdHit(ioRdHit),
  .altBase(altBase), .priIrq(priIrq), .raOff(raOff), .secEn(secEn)
);

// File: tb/test_idx_cfg_window.sv
module test_idx_cfg_window;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ioAddr = 16'h0;
  logic        ioWr = 1'b0, ioRd = 1'b0;
  logic [7:0]  ioWrData = 8'h0;
  logic [7:0]  ioRdData;
  logic        ioRdHit;
  logic        altBase = 1'b0;
  logic        priIrq = 1'b0, secIrq = 1'b0, priStatRd = 1'b0, secStatRd = 1'b0;
  logic [3:0]  raOff;
  logic        secEn;

  int nVec = 0, nBad = 0;
  bit done = 0;

  // model state built from the requirements
  logic [7:0] mdl [12];
  bit mPri = 0, mSec = 0;

  always #4 clk = ~clk;

  idx_cfg_window i_idx_cfg_window (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .ioRdHit(ioRdHit),
    .altBase(altBase), .priIrq(priIrq), .secIrq(secIrq),
    .priStatRd(priStatRd), .secStatRd(secStatRd), .raOff(raOff), .secEn(secEn)
  );

  function automatic logic [15:0] baseOf();
    return altBase ? 16'h0078 : 16'h0178;
  endfunction

  function automatic logic [7:0] maskOf(input int s);
    if (s == 0) return 8'hD8;
    if (s == 7) return 8'hEF;
    if (s == 10) return 8'h00;
    return 8'hFF;
  endfunction

  function automatic bit implIdx(input logic [7:0] i);
    return (i >= 8'h50) && (i <= 8'h5B) && (i != 8'h5A);
  endfunction

  function automatic logic [7:0] expData(input logic [7:0] i);
    logic [7:0] v;
    int s;
    if (!implIdx(i)) return 8'hFF;
    s = int'(i) - 'h50;
    v = mdl[s];
    if (s == 0) v = (v & 8'hD8) | {2'b00, altBase, 2'b00, mPri, 2'd2};
    if (s == 7) v = (v & 8'hEF) | {3'b000, mSec, 4'b0000};
    return v;
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nVec++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wrPort(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic rdPort(input logic [15:0] a, output logic [7:0] d, output logic h);
    @(negedge clk);
    ioAddr = a; ioRd = 1'b1;
    @(posedge clk);
    #1;
    d = ioRdData; h = ioRdHit;
    ioRd = 1'b0;
  endtask

  task automatic wrReg(input logic [7:0] i, input logic [7:0] d);
    wrPort(baseOf(), i);
    wrPort(baseOf() + 16'd4, d);
    if (implIdx(i)) begin
      int s = int'(i) - 'h50;
      mdl[s] = (mdl[s] & ~maskOf(s)) | (d & maskOf(s));
    end
  endtask

  task automatic rdReg(input logic [7:0] i, output logic [7:0] d);
    logic h;
    wrPort(baseOf(), i);
    rdPort(baseOf() + 16'd4, d, h);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: priIrq = 1'b1;
      1: secIrq = 1'b1;
      2: priStatRd = 1'b1;
      3: secStatRd = 1'b1;
      default: begin secIrq = 1'b1; secStatRd = 1'b1; end
    endcase
    @(negedge clk);
    priIrq = 1'b0; secIrq = 1'b0; priStatRd = 1'b0; secStatRd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nVec++; nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    logic h;
    for (int s = 0; s < 12; s++) mdl[s] = (s == 9) ? 8'h40 : 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R6 reset values, R4 revision, R3 flag at main base
    for (int i = 'h50; i <= 'h5B; i++) begin
      rdReg(8'(i), d);
      check($sformatf("R6 reset idx %h", i), d, expData(8'(i)));
    end
    rdReg(8'h50, d);
    check("R4 revision after reset", {6'b0, d[1:0]}, 8'h02);
    check("R3 base flag at 0x178", {7'b0, d[5]}, 8'h00);

    // R1 index port read-back
    foreach (d2[k]) begin
      logic [7:0] v = 8'h01 << k;
      wrPort(baseOf(), v ^ 8'h5A);
      rdPort(baseOf(), d, h);
      check("R1 index readback", d, v ^ 8'h5A);
      check("R1 index hit", {7'b0, h}, 8'h01);
    end

    // R7/R8 sweep over indexes around the bank
    for (int i = 'h40; i <= 'h6F; i++) begin
      logic [7:0] v = 8'(i * 29) ^ 8'h6C;
      wrReg(8'(i), v);
      rdReg(8'(i), d);
      check(implIdx(8'(i)) ? $sformatf("R8 readback idx %h", i)
                           : $sformatf("R7 unimplemented idx %h", i), d, expData(8'(i)));
    end
    for (int i = 'h50; i <= 'h5B; i++) begin
      rdReg(8'(i), d);
      check($sformatf("R7 no side effect idx %h", i), d, expData(8'(i)));
    end
    foreach (d2[k]) begin
      wrReg(8'h5B, 8'hBD ^ (8'h01 << k));
      rdReg(8'h5B, d);
      check("R8 scratch", d, 8'hBD ^ (8'h01 << k));
    end

    // R9 control outputs
    for (int p = 0; p < 16; p++) begin
      logic [7:0] a = {p[1], p[0], 2'b00, p[2], 3'b000};
      logic [7:0] b = {4'h0, p[3], p[2], 2'b00};
      wrReg(8'h51, a);
      wrReg(8'h57, b);
      @(negedge clk);
      check("R9 raOff", {4'b0, raOff}, {4'b0, b[3], b[2], a[7], a[6]});
      check("R9 secEn", {7'b0, secEn}, {7'b0, a[3]});
    end

    // R5 pending flags, R4 and R3 under host writes
    pulse(0); mPri = 1;
    rdReg(8'h50, d);
    check("R5 primary set", d, expData(8'h50));
    rdReg(8'h57, d);
    check("R5 secondary untouched", d, expData(8'h57));
    wrReg(8'h50, 8'h00);
    rdReg(8'h50, d);
    check("R5 write ignored on pending", d, expData(8'h50));
    pulse(2); mPri = 0;
    rdReg(8'h50, d);
    check("R5 primary cleared", d, expData(8'h50));
    wrReg(8'h50, 8'hFF);
    rdReg(8'h50, d);
    check("R5 write of ones ignored", d, expData(8'h50));
    check("R4 revision after ones", {6'b0, d[1:0]}, 8'h02);
    check("R3 flag after ones", {7'b0, d[5]}, 8'h00);
    pulse(1); mSec = 1;
    wrReg(8'h57, 8'h00);
    rdReg(8'h57, d);
    check("R5 secondary set", d, expData(8'h57));
    pulse(3); mSec = 0;
    rdReg(8'h57, d);
    check("R5 secondary cleared", d, expData(8'h57));
    pulse(4); mSec = 1;
    rdReg(8'h57, d);
    check("R10 set beats clear", d, expData(8'h57));
    pulse(3); mSec = 0;

    // R2 inactive base ignored at main base
    wrPort(baseOf(), 8'h5B);
    wrPort(16'h0078, 8'h52);
    wrPort(16'h007C, 8'h11);
    rdPort(16'h007C, d, h);
    check("R2 alt data port silent", {h, d[6:0]}, 8'h00);
    rdPort(16'h0078, d, h);
    check("R2 alt index port silent", {7'b0, h}, 8'h00);
    rdPort(baseOf(), d, h);
    check("R2 index kept", d, 8'h5B);
    rdPort(baseOf() + 16'd4, d, h);
    check("R2 register kept", d, expData(8'h5B));

    // switch strap to the alternate base
    @(negedge clk); altBase = 1'b1;
    rdReg(8'h50, d);
    check("R3 base flag at 0x78", d, expData(8'h50));
    wrReg(8'h5B, 8'h3C);
    rdReg(8'h5B, d);
    check("R2 alt base works", d, 8'h3C);
    wrPort(16'h0178, 8'h51);
    wrPort(16'h017C, 8'hFF);
    rdPort(16'h017C, d, h);
    check("R2 main base silent", {h, d[6:0]}, 8'h00);
    for (int i = 'h50; i <= 'h5B; i++) begin
      rdReg(8'(i), d);
      check($sformatf("R2 bank kept idx %h", i), d, expData(8'(i)));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule